// File: doc/BRIEF.md
# Debug communications channel mailbox

A two-sided mailbox that passes words between a processor core and an external debugger. It holds one transmit word, which the core fills and the debugger drains, and one receive word, which the debugger fills and the core drains. Each word has a full flag. The effect of an access on a flag depends on which side makes it and in which direction. The debugger can also submit an instruction word to the core through a single-entry slot. The slot stays occupied until the core reports that the instruction is complete.

The core side offers a 32-bit transmit write, a 32-bit receive read and a combined 64-bit access that moves both words at once. The combined access places the words in different halves for a read than for a write. The debugger side can read and write both words. It sees both full flags, the instruction-slot state and four sticky error bits. A protocol violation by the debugger sets the matching sticky bit and the cumulative error bit. The debugger clears the sticky bits with a write-one-to-clear strobe.

All read data is driven combinationally from the stored words, so it shows the value held before the access. Every flag and word update lands on the next rising clock edge.

Top module: `dcc_mailbox`

## Requirements
- R1: A core 32-bit transmit write loads the transmit word and sets `tx_full` to 1.
- R2: A core 32-bit receive read returns the receive word on `core_rx_rdata` in the same cycle and clears `rx_full` to 0.
- R3: A core 64-bit write puts bits [31:0] into the transmit word and bits [63:32] into the receive word. It sets `tx_full` and leaves `rx_full` unchanged.
- R4: A core 64-bit read returns the receive word in bits [31:0] and the transmit word in bits [63:32]. It clears `rx_full` and leaves `tx_full` unchanged.
- R5: A debugger transmit read returns the transmit word and clears `tx_full`. A debugger transmit write replaces the word and leaves `tx_full` unchanged.
- R6: A debugger receive read returns the receive word and leaves `rx_full` unchanged. A debugger receive write while `rx_full` is 0 loads the word and sets `rx_full` to 1.
- R7: A debugger transmit read while `tx_full` is 0 returns the stale word and sets the underrun bit, `dbg_err_flags[0]`.
- R8: A debugger receive write while `rx_full` is 1 drops the data and sets the overrun bit, `dbg_err_flags[1]`.
- R9: A debugger instruction write while `dbg_ins_empty` is 1 loads `ins_word` and raises `ins_pending`. `ins_done` empties the slot again. An instruction write while the slot is occupied is discarded and sets `dbg_err_flags[2]`.
- R10: Bits [2:0] of `dbg_err_flags` are sticky, and any of them being set also sets the cumulative bit [3]. When `dbg_err_clr` is high, each bit whose mask bit (same position) is 1 is cleared. A bit being set in the same cycle wins over its clear.
- R11: When the core and the debugger access the same word in one cycle, the core access wins. A core transmit write together with a debugger transmit read leaves `tx_full` at 1 and stores the core data. A core receive read together with a debugger receive write leaves `rx_full` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_tx_wr | input | 1 | Core 32-bit transmit write strobe |
| core_tx_wdata | input | 32 | Core transmit write data |
| core_rx_rd | input | 1 | Core 32-bit receive read strobe |
| core_rx_rdata | output | 32 | Receive word as seen by the core |
| core_dw_wr | input | 1 | Core combined 64-bit write strobe |
| core_dw_wdata | input | 64 | Combined write data: [31:0] transmit, [63:32] receive |
| core_dw_rd | input | 1 | Core combined 64-bit read strobe |
| core_dw_rdata | output | 64 | Combined read data: [31:0] receive, [63:32] transmit |
| dbg_tx_rd | input | 1 | Debugger transmit read strobe |
| dbg_tx_rdata | output | 32 | Transmit word as seen by the debugger |
| dbg_tx_wr | input | 1 | Debugger transmit write strobe |
| dbg_tx_wdata | input | 32 | Debugger transmit write data |
| dbg_rx_rd | input | 1 | Debugger receive read strobe |
| dbg_rx_rdata | output | 32 | Receive word as seen by the debugger |
| dbg_rx_wr | input | 1 | Debugger receive write strobe |
| dbg_rx_wdata | input | 32 | Debugger receive write data |
| dbg_ins_wr | input | 1 | Debugger instruction submit strobe |
| dbg_ins_wdata | input | 32 | Instruction word |
| ins_done | input | 1 | Core reports that the pending instruction is complete |
| ins_word | output | 32 | Pending instruction word |
| ins_pending | output | 1 | Instruction slot occupied |
| dbg_ins_empty | output | 1 | Instruction slot free, as seen by the debugger |
| dbg_err_clr | input | 1 | Write-one-to-clear strobe for the error bits |
| dbg_err_clr_mask | input | 4 | Bits to clear, same positions as `dbg_err_flags` |
| dbg_err_flags | output | 4 | [0] underrun, [1] overrun, [2] instruction overrun, [3] cumulative |
| tx_full | output | 1 | Transmit word full flag, visible to both sides |
| rx_full | output | 1 | Receive word full flag, visible to both sides |

## Verification
Read data has no register between the stored word and the port, so it is due in the same cycle as the read strobe. The bench checks it one time step after driving the strobe, before the clock edge. Flags, stored words, the instruction slot and the error bits change on the first rising edge after the strobe. The bench therefore releases the strobes and checks these results shortly after that edge, when exactly one update has taken effect. Same-cycle collisions and set-against-clear of the error bits are driven within a single cycle, so the one edge shows which access won.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned ERR_TXU = 0;
  localparam int unsigned ERR_RXO = 1;
  localparam int unsigned ERR_INO = 2;
  localparam int unsigned ERR_SRC = 3;
  localparam int unsigned ERR_CUM = ERR_SRC;
  localparam int unsigned ERR_W   = ERR_SRC + 1;

  typedef logic [ERR_SRC-1:0] err_evt_t;
  typedef logic [ERR_W-1:0]   err_vec_t;
endpackage

// File: rtl/dcc_tx_word.sv
module dcc_tx_word #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_ld,
  input  logic [DW-1:0] core_data,
  input  logic          dbg_rd,
  input  logic          dbg_ld,
  input  logic [DW-1:0] dbg_data,
  output logic [DW-1:0] word,
  output logic          full,
  output logic          under_evt
);
  logic [DW-1:0] word_q, word_d;
  logic          full_q, full_d;
  logic          word_en, flag_en;

  always_comb begin
    word_d  = word_q;
    full_d  = full_q;
    word_en = core_ld | dbg_ld;
    flag_en = core_ld | dbg_rd;
    if (core_ld)     word_d = core_data;
    else if (dbg_ld) word_d = dbg_data;
    if (core_ld)     full_d = 1'b1;
    else if (dbg_rd) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (word_en) word_q <= word_d;
      if (flag_en) full_q <= full_d;
    end
  end

  assign word      = word_q;
  assign full      = full_q;
  assign under_evt = dbg_rd & ~full_q;

  assert_core_load_sets_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_ld |=> full_q);
  assert_dbg_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd && !core_ld) |=> !full_q);
  assert_dbg_write_keeps_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ld && !core_ld && !dbg_rd) |=> $stable(full_q));
  assert_core_data_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_ld |=> (word_q == $past(core_data)));
endmodule

// File: rtl/dcc_rx_word.sv
module dcc_rx_word #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_ld,
  input  logic [DW-1:0] core_data,
  input  logic          core_rd,
  input  logic          dbg_ld,
  input  logic [DW-1:0] dbg_data,
  output logic [DW-1:0] word,
  output logic          full,
  output logic          over_evt
);
  logic [DW-1:0] word_q, word_d;
  logic          full_q, full_d;
  logic          accept, word_en, flag_en;

  always_comb begin
    accept  = dbg_ld & ~full_q & ~core_ld;
    word_d  = word_q;
    full_d  = full_q;
    word_en = core_ld | accept;
    flag_en = core_rd | accept;
    if (core_ld)     word_d = core_data;
    else if (accept) word_d = dbg_data;
    if (core_rd)     full_d = 1'b0;
    else if (accept) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (word_en) word_q <= word_d;
      if (flag_en) full_q <= full_d;
    end
  end

  assign word     = word_q;
  assign full     = full_q;
  assign over_evt = dbg_ld & full_q;

  assert_core_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd |=> !full_q);
  assert_core_dw_write_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ld && !core_rd) |=> $stable(full_q));
  assert_dbg_write_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ld && !full_q && !core_ld && !core_rd) |=> full_q);
  assert_overrun_drops_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ld && full_q && !core_ld) |=> $stable(word_q));
endmodule

// File: rtl/dcc_ins_slot.sv
module dcc_ins_slot #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_ld,
  input  logic [DW-1:0] dbg_data,
  input  logic          done,
  output logic [DW-1:0] word,
  output logic          empty,
  output logic          over_evt
);
  logic [DW-1:0] word_q, word_d;
  logic          empty_q, empty_d;
  logic          accept, slot_en;

  always_comb begin
    accept  = dbg_ld & empty_q;
    word_d  = accept ? dbg_data : word_q;
    empty_d = empty_q;
    if (accept)    empty_d = 1'b0;
    else if (done) empty_d = 1'b1;
    slot_en = accept | done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      empty_q <= 1'b1;
    end else if (slot_en) begin
      word_q  <= word_d;
      empty_q <= empty_d;
    end
  end

  assign word     = word_q;
  assign empty    = empty_q;
  assign over_evt = dbg_ld & ~empty_q;

  assert_accept_fills_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ld && empty_q) |=> !empty_q);
  assert_busy_write_discarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ld && !empty_q) |=> $stable(word_q));
  assert_done_frees_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dbg_ld) |=> empty_q);
endmodule

// File: rtl/dcc_err_sticky.sv
module dcc_err_sticky
  import dcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_evt_t set_evt,
  input  logic     clr,
  input  err_vec_t clr_mask,
  output err_vec_t flags
);
  err_vec_t flags_q, flags_d;
  err_vec_t set_all;
  logic     flag_en;

  assign set_all = {|set_evt, set_evt};

  for (genvar i = 0; i < int'(ERR_W); i++) begin : g_bit
    always_comb begin
      flags_d[i] = set_all[i] | (flags_q[i] & ~(clr & clr_mask[i]));
    end
  end

  assign flag_en = clr | (|set_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (flag_en) flags_q <= flags_d;
  end

  assign flags = flags_q;

  for (genvar i = 0; i < int'(ERR_SRC); i++) begin : g_chk
    assert_event_sets_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags_q[i]);
  end

  assert_cumulative_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> flags_q[ERR_CUM]);
  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && set_evt == '0) |=> $stable(flags_q));
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_tx_wr,
  input  logic [DW-1:0]   core_tx_wdata,
  input  logic            core_rx_rd,
  output logic [DW-1:0]   core_rx_rdata,
  input  logic            core_dw_wr,
  input  logic [2*DW-1:0] core_dw_wdata,
  input  logic            core_dw_rd,
  output logic [2*DW-1:0] core_dw_rdata,
  input  logic            dbg_tx_rd,
  output logic [DW-1:0]   dbg_tx_rdata,
  input  logic            dbg_tx_wr,
  input  logic [DW-1:0]   dbg_tx_wdata,
  input  logic            dbg_rx_rd,
  output logic [DW-1:0]   dbg_rx_rdata,
  input  logic            dbg_rx_wr,
  input  logic [DW-1:0]   dbg_rx_wdata,
  input  logic            dbg_ins_wr,
  input  logic [DW-1:0]   dbg_ins_wdata,
  input  logic            ins_done,
  output logic [DW-1:0]   ins_word,
  output logic            ins_pending,
  output logic            dbg_ins_empty,
  input  logic            dbg_err_clr,
  input  logic [ERR_W-1:0] dbg_err_clr_mask,
  output logic [ERR_W-1:0] dbg_err_flags,
  output logic            tx_full,
  output logic            rx_full
);
  localparam int unsigned LO_HI = DW;

  logic          tx_core_ld, rx_core_ld, rx_core_rd;
  logic [DW-1:0] tx_core_data;
  logic [DW-1:0] tx_word, rx_word, slot_word;
  logic          tx_under, rx_over, ins_over, slot_empty;
  err_evt_t      err_evt;

  always_comb begin
    tx_core_ld   = core_tx_wr | core_dw_wr;
    tx_core_data = core_dw_wr ? core_dw_wdata[LO_HI-1:0] : core_tx_wdata;
    rx_core_ld   = core_dw_wr;
    rx_core_rd   = core_rx_rd | core_dw_rd;
  end

  dcc_tx_word #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .core_ld(tx_core_ld), .core_data(tx_core_data),
    .dbg_rd(dbg_tx_rd), .dbg_ld(dbg_tx_wr), .dbg_data(dbg_tx_wdata),
    .word(tx_word), .full(tx_full), .under_evt(tx_under)
  );

  dcc_rx_word #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .core_ld(rx_core_ld), .core_data(core_dw_wdata[2*DW-1:LO_HI]),
    .core_rd(rx_core_rd), .dbg_ld(dbg_rx_wr), .dbg_data(dbg_rx_wdata),
    .word(rx_word), .full(rx_full), .over_evt(rx_over)
  );

  dcc_ins_slot #(.DW(DW)) u_ins (
    .clk(clk), .rst_n(rst_n),
    .dbg_ld(dbg_ins_wr), .dbg_data(dbg_ins_wdata), .done(ins_done),
    .word(slot_word), .empty(slot_empty), .over_evt(ins_over)
  );

  always_comb begin
    err_evt          = '0;
    err_evt[ERR_TXU] = tx_under;
    err_evt[ERR_RXO] = rx_over;
    err_evt[ERR_INO] = ins_over;
  end

  dcc_err_sticky u_err (
    .clk(clk), .rst_n(rst_n),
    .set_evt(err_evt), .clr(dbg_err_clr), .clr_mask(dbg_err_clr_mask),
    .flags(dbg_err_flags)
  );

  assign core_rx_rdata = rx_word;
  assign dbg_rx_rdata  = rx_word;
  assign dbg_tx_rdata  = tx_word;
  assign core_dw_rdata = {tx_word, rx_word};
  assign ins_word      = slot_word;
  assign ins_pending   = ~slot_empty;
  assign dbg_ins_empty = slot_empty;

  assert_core_single_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_tx_wr, core_rx_rd, core_dw_wr, core_dw_rd}));
  assert_dw_read_keeps_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_dw_rd && !dbg_tx_rd && !dbg_tx_wr) |=> $stable(tx_full));
  assert_dbg_rx_read_keeps_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rx_rd && !dbg_rx_wr && !rx_core_rd) |=> $stable(rx_full));
endmodule

// File: tb/sim_dcc_mailbox.sv
`timescale 1ns/1ps
module sim_dcc_mailbox;
  logic        clk, rst_n;
  logic        core_tx_wr, core_rx_rd, core_dw_wr, core_dw_rd;
  logic [31:0] core_tx_wdata, core_rx_rdata;
  logic [63:0] core_dw_wdata, core_dw_rdata;
  logic        dbg_tx_rd, dbg_tx_wr, dbg_rx_rd, dbg_rx_wr, dbg_ins_wr, ins_done;
  logic [31:0] dbg_tx_rdata, dbg_tx_wdata, dbg_rx_rdata, dbg_rx_wdata, dbg_ins_wdata, ins_word;
  logic        ins_pending, dbg_ins_empty, dbg_err_clr, tx_full, rx_full;
  logic [3:0]  dbg_err_clr_mask, dbg_err_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  dcc_mailbox u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    core_tx_wr = 0; core_rx_rd = 0; core_dw_wr = 0; core_dw_rd = 0;
    dbg_tx_rd = 0; dbg_tx_wr = 0; dbg_rx_rd = 0; dbg_rx_wr = 0;
    dbg_ins_wr = 0; ins_done = 0; dbg_err_clr = 0; dbg_err_clr_mask = 4'h0;
  endtask

  task automatic step();
    @(posedge clk); #2; idle(); #1;
  endtask

  task automatic clear_all();
    dbg_err_clr = 1; dbg_err_clr_mask = 4'hF; step();
  endtask

  task automatic t_reset();
    chk("R1 reset tx_full", tx_full, 0);
    chk("R2 reset rx_full", rx_full, 0);
    chk("R9 reset slot", {ins_pending, dbg_ins_empty}, 2'b01);
    chk("R10 reset flags", dbg_err_flags, 0);
  endtask

  task automatic t_core_tx();
    core_tx_wr = 1; core_tx_wdata = 32'hA5A5_0001; step();
    chk("R1 tx_full", tx_full, 1);
    chk("R1 tx word", dbg_tx_rdata, 32'hA5A5_0001);
  endtask

  task automatic t_dbg_tx_rw();
    dbg_tx_rd = 1; #1;
    chk("R5 dbg tx rdata", dbg_tx_rdata, 32'hA5A5_0001);
    step();
    chk("R5 read clears", tx_full, 0);
    chk("R5 no error", dbg_err_flags, 0);
    dbg_tx_wr = 1; dbg_tx_wdata = 32'h0000_BEEF; step();
    chk("R5 write word", dbg_tx_rdata, 32'h0000_BEEF);
    chk("R5 write keeps flag", tx_full, 0);
  endtask

  task automatic t_underrun();
    dbg_tx_rd = 1; #1;
    chk("R7 stale word", dbg_tx_rdata, 32'h0000_BEEF);
    step();
    chk("R7 underrun bits", dbg_err_flags, 4'b1001);
    clear_all();
    chk("R10 cleared", dbg_err_flags, 0);
  endtask

  task automatic t_dbg_rx();
    dbg_rx_wr = 1; dbg_rx_wdata = 32'hC0DE_0003; step();
    chk("R6 rx_full set", rx_full, 1);
    chk("R6 rx word", core_rx_rdata, 32'hC0DE_0003);
    dbg_rx_rd = 1; #1;
    chk("R6 dbg rx rdata", dbg_rx_rdata, 32'hC0DE_0003);
    step();
    chk("R6 read keeps flag", rx_full, 1);
  endtask

  task automatic t_overrun();
    dbg_rx_wr = 1; dbg_rx_wdata = 32'hDEAD_0004; step();
    chk("R8 data dropped", dbg_rx_rdata, 32'hC0DE_0003);
    chk("R8 overrun bits", dbg_err_flags, 4'b1010);
    clear_all();
  endtask

  task automatic t_core_rx();
    core_rx_rd = 1; #1;
    chk("R2 core rdata", core_rx_rdata, 32'hC0DE_0003);
    step();
    chk("R2 read clears", rx_full, 0);
  endtask

  task automatic t_dw();
    core_dw_wr = 1; core_dw_wdata = 64'h1111_2222_3333_4444; step();
    chk("R3 tx low word", dbg_tx_rdata, 32'h3333_4444);
    chk("R3 rx high word", dbg_rx_rdata, 32'h1111_2222);
    chk("R3 flags", {tx_full, rx_full}, 2'b10);
    dbg_rx_wr = 1; dbg_rx_wdata = 32'h5555_6666; step();
    core_dw_rd = 1; #1;
    chk("R4 swapped order", core_dw_rdata, 64'h3333_4444_5555_6666);
    step();
    chk("R4 flags", {tx_full, rx_full}, 2'b10);
  endtask

  task automatic t_collide();
    dbg_tx_rd = 1; step();
    core_tx_wr = 1; core_tx_wdata = 32'hF00D_0007; dbg_tx_rd = 1; step();
    chk("R11 tx_full core wins", tx_full, 1);
    chk("R11 tx word core wins", dbg_tx_rdata, 32'hF00D_0007);
    clear_all();
    core_rx_rd = 1; dbg_rx_wr = 1; dbg_rx_wdata = 32'h0A0B_0C0D; step();
    chk("R11 rx_full core wins", rx_full, 0);
  endtask

  task automatic t_ins();
    dbg_ins_wr = 1; dbg_ins_wdata = 32'h1234_5678; step();
    chk("R9 slot loaded", {ins_pending, dbg_ins_empty}, 2'b10);
    chk("R9 ins word", ins_word, 32'h1234_5678);
    dbg_ins_wr = 1; dbg_ins_wdata = 32'h8765_4321; step();
    chk("R9 busy discarded", ins_word, 32'h1234_5678);
    chk("R9 ins overrun bits", dbg_err_flags, 4'b1100);
    ins_done = 1; step();
    chk("R9 done frees", {ins_pending, dbg_ins_empty}, 2'b01);
    clear_all();
  endtask

  task automatic t_set_vs_clear();
    dbg_tx_rd = 1; step();
    dbg_tx_rd = 1; dbg_err_clr = 1; dbg_err_clr_mask = 4'hF; step();
    chk("R10 set beats clear", dbg_err_flags, 4'b1001);
    dbg_err_clr = 1; dbg_err_clr_mask = 4'b0001; step();
    chk("R10 selective clear", dbg_err_flags, 4'b1000);
    dbg_err_clr = 1; dbg_err_clr_mask = 4'b1000; step();
    chk("R10 cumulative clear", dbg_err_flags, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    core_tx_wdata = '0; core_dw_wdata = '0; dbg_tx_wdata = '0;
    dbg_rx_wdata = '0; dbg_ins_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1; #1;
    t_reset();
    t_core_tx();
    t_dbg_tx_rw();
    t_underrun();
    t_dbg_rx();
    t_overrun();
    t_core_rx();
    t_dw();
    t_collide();
    t_ins();
    t_set_vs_clear();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule